// File: doc/BRIEF.md
# Processor Status Register Update Unit

This block keeps the eight-bit processor status word. The word holds three arithmetic flags (zero, half carry, carry), two reset-cause flags that report a sleep entry and a watchdog expiry, and three data-memory bank select bits. Each cycle, two update sources may target the register at once. An instruction may name the register as its destination and write a full byte. The ALU may also post new flag values. The unit merges both sources into the next register value.

The instruction decoder supplies the per-flag update enables. Flags that the current instruction affects take the ALU value, and the written byte's value for those bits is discarded. Flags that the instruction leaves alone take the written byte. This covers bit set, bit clear, nibble swap and a move from the accumulator, which affect no flags. The two reset-cause bits never follow a write. A synchronous reset sets both of them. Two event inputs clear them, and they stay clear until the next reset. The output always shows the registered value, so a write becomes visible one clock after it is applied.

Top module: `stat_reg_unit`

## Requirements
- R1: Synchronous reset (`rst_n` low at a rising edge) loads 0x18: the watchdog flag (bit 4) and sleep flag (bit 3) are 1 and all other bits are 0.
- R2: A write (`wr_en`=1) with no flag update enables loads bits 7:5 and 2:0 from `wr_data` on the next edge.
- R3: For each flag i (bit 2 zero, bit 1 half carry, bit 0 carry), when `flag_upd_en[i]`=1 the flag takes `flag_upd_val[i]` even if a write is applied in the same cycle. Flags whose enable is 0 take the written value.
- R4: Without a write, flags with an enable take the ALU value and flags without one hold their value.
- R5: Bits 4 and 3 ignore every write. Writing 0 or 1 to them leaves them unchanged.
- R6: `sleep_evt`=1 clears bit 3 and `wdt_evt`=1 clears bit 4 on the next edge, also during a write. Once clear, a bit stays 0 until reset.
- R7: In the cycle where a write is applied, `status_q` still shows the old value. The new value appears after the next rising edge.
- R8: Bank bits 7:5 hold their value when no write is applied, whatever the flag updates do.
- R9: A register clear (write of 0x00 with only the zero-flag update enabled at value 1) gives bank bits 0, zero flag 1, half carry and carry 0, and leaves the reset-cause bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Instruction writes the status register this cycle |
| wr_data | input | 8 | Byte written when `wr_en` is high |
| flag_upd_en | input | 3 | Per-flag ALU update enable: [2] zero, [1] half carry, [0] carry |
| flag_upd_val | input | 3 | ALU flag values, same bit order as `flag_upd_en` |
| sleep_evt | input | 1 | Sleep entry event, clears bit 3 |
| wdt_evt | input | 1 | Watchdog expiry event, clears bit 4 |
| status_q | output | 8 | Registered status word |

## Verification
The hardest case is a single cycle that carries a write, a partial set of flag enables and a reset-cause event together. Each bit of the result then comes from a different source. The vector table drives byte values whose flag bits oppose the ALU values, so each bit shows which source won. A reset-cause bit is cleared first and then written with a 1, which shows that writes cannot set it again. Directed steps then probe the value in the write cycle itself and a write that coincides with a watchdog event.

// File: rtl/stat_pkg.sv
// Shared constants for the status register unit.
// Assumes the bit layout (bank bits on top, reset causes in the middle,
// arithmetic flags at the bottom) is decoded by neighbouring logic.
package stat_pkg;
    localparam int STAT_W    = 8;
    localparam int FLAG_N    = 3;
    localparam int CAUSE_N   = 2;
    localparam int BANK_W    = STAT_W - FLAG_N - CAUSE_N;
    localparam int FLAG_LSB  = 0;
    localparam int CAUSE_LSB = FLAG_LSB + FLAG_N;
    localparam int BANK_LSB  = CAUSE_LSB + CAUSE_N;
    localparam int BIT_SLP   = CAUSE_LSB;      // sleep flag, active low
    localparam int BIT_WDT   = CAUSE_LSB + 1;  // watchdog flag, active low
    localparam int BIT_ZERO  = FLAG_LSB + 2;
    localparam logic [STAT_W-1:0] STAT_RST =
        STAT_W'((1 << BIT_SLP) | (1 << BIT_WDT));
endpackage

// File: rtl/stat_flag_merge.sv
// Per-flag next-value select for the arithmetic flags.
// Assumes the enables come already decoded per flag; an enabled ALU
// update always wins over a direct write to the same bit.
module stat_flag_merge #(
    parameter int N = 3
) (
    input  logic         wr_en,
    input  logic [N-1:0] wr_bits,
    input  logic [N-1:0] upd_en,
    input  logic [N-1:0] upd_val,
    input  logic [N-1:0] cur,
    output logic [N-1:0] nxt
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Pick the source for flag i: ALU, then write, then hold.
        always_comb begin
            if (upd_en[i])
                nxt[i] = upd_val[i];
            else if (wr_en)
                nxt[i] = wr_bits[i];
            else
                nxt[i] = cur[i];
        end
    end
endmodule

// File: rtl/stat_bank_merge.sv
// Next-value select for the bank select field.
// Assumes only a direct write changes the field; ALU activity never does.
module stat_bank_merge #(
    parameter int W = 3
) (
    input  logic         wr_en,
    input  logic [W-1:0] wr_bits,
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    // Load on write, otherwise hold.
    always_comb begin
        nxt = wr_en ? wr_bits : cur;
    end
endmodule

// File: rtl/stat_cause_next.sv
// Next-value logic for the two active-low reset-cause flags.
// Assumes reset (handled by the owner of the register) is the only way
// to set them; events only clear them and software writes never reach here.
module stat_cause_next (
    input  logic slp_n_cur,
    input  logic wdt_n_cur,
    input  logic sleep_evt,
    input  logic wdt_evt,
    output logic slp_n_nxt,
    output logic wdt_n_nxt
);
    // Clear-only update of each cause flag.
    always_comb begin
        slp_n_nxt = slp_n_cur & ~sleep_evt;
        wdt_n_nxt = wdt_n_cur & ~wdt_evt;
    end
endmodule

// File: rtl/stat_reg_unit.sv
// Status register: merges a direct destination write with per-flag ALU
// updates and reset-cause events into one registered byte.
// Assumes decoded per-flag enables and single-cycle event pulses from outside.
module stat_reg_unit
    import stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    input  logic [FLAG_N-1:0] flag_upd_en,
    input  logic [FLAG_N-1:0] flag_upd_val,
    input  logic              sleep_evt,
    input  logic              wdt_evt,
    output logic [STAT_W-1:0] status_q
);
    logic [FLAG_N-1:0] flag_nxt;
    logic [BANK_W-1:0] bank_nxt;
    logic              slp_n_nxt;
    logic              wdt_n_nxt;
    logic [STAT_W-1:0] stat_nxt;

    stat_flag_merge #(.N(FLAG_N)) u_flags (
        .wr_en   (wr_en),
        .wr_bits (wr_data[FLAG_LSB +: FLAG_N]),
        .upd_en  (flag_upd_en),
        .upd_val (flag_upd_val),
        .cur     (status_q[FLAG_LSB +: FLAG_N]),
        .nxt     (flag_nxt)
    );

    stat_bank_merge #(.W(BANK_W)) u_bank (
        .wr_en   (wr_en),
        .wr_bits (wr_data[BANK_LSB +: BANK_W]),
        .cur     (status_q[BANK_LSB +: BANK_W]),
        .nxt     (bank_nxt)
    );

    stat_cause_next u_cause (
        .slp_n_cur (status_q[BIT_SLP]),
        .wdt_n_cur (status_q[BIT_WDT]),
        .sleep_evt (sleep_evt),
        .wdt_evt   (wdt_evt),
        .slp_n_nxt (slp_n_nxt),
        .wdt_n_nxt (wdt_n_nxt)
    );

    // Assemble the next word from the three field selectors.
    always_comb begin
        stat_nxt                         = '0;
        stat_nxt[FLAG_LSB +: FLAG_N]     = flag_nxt;
        stat_nxt[BANK_LSB +: BANK_W]     = bank_nxt;
        stat_nxt[BIT_SLP]                = slp_n_nxt;
        stat_nxt[BIT_WDT]                = wdt_n_nxt;
    end

    // The single status register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= STAT_RST;
        else
            status_q <= stat_nxt;
    end

    // R1: reset value
    p_reset_value_r1: assert property (@(posedge clk)
        !rst_n |=> status_q == STAT_RST);

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag_chk
        // R3: enabled ALU update wins for this flag
        p_alu_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
            flag_upd_en[i] |=> status_q[FLAG_LSB+i] == $past(flag_upd_val[i]));
        // R2: unaffected flag follows the write
        p_write_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !flag_upd_en[i]) |=> status_q[FLAG_LSB+i] == $past(wr_data[FLAG_LSB+i]));
        // R4: no source means hold
        p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en && !flag_upd_en[i]) |=> $stable(status_q[FLAG_LSB+i]));
    end

    // R5: a written 1 cannot revive a cleared cause flag
    p_cause_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[BIT_SLP] && !status_q[BIT_SLP]) |=> !status_q[BIT_SLP]);
    p_wdt_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[BIT_WDT] && !status_q[BIT_WDT]) |=> !status_q[BIT_WDT]);
    // R5: without events the cause bits do not move
    p_cause_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_evt && !wdt_evt) |=> $stable(status_q[BIT_WDT:BIT_SLP]));
    // R6: events clear their flag
    p_sleep_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_evt |=> !status_q[BIT_SLP]);
    p_wdt_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_evt |=> !status_q[BIT_WDT]);
    // R8: bank bits hold without a write
    p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(status_q[BANK_LSB +: BANK_W]));
endmodule

// File: tb/stat_reg_unit_tb.sv
// Vector-table bench for stat_reg_unit, followed by directed corner cases.
module stat_reg_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] flag_upd_en = '0;
    logic [2:0] flag_upd_val = '0;
    logic       sleep_evt = 1'b0;
    logic       wdt_evt = 1'b0;
    logic [7:0] status_q;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    stat_reg_unit u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .flag_upd_en  (flag_upd_en),
        .flag_upd_val (flag_upd_val),
        .sleep_evt    (sleep_evt),
        .wdt_evt      (wdt_evt),
        .status_q     (status_q)
    );

    // Layout: [28:25] req, [24] wr, [23:16] data, [15:13] en, [12:10] val,
    // [9] sleep, [8] wdt, [7:0] expected status after the edge.
    localparam int NV = 12;
    localparam logic [28:0] VECS [NV] = '{
        {4'd2, 1'b1, 8'hFF, 3'b000, 3'b000, 1'b0, 1'b0, 8'hFF}, // R2
        {4'd5, 1'b1, 8'h00, 3'b000, 3'b000, 1'b0, 1'b0, 8'h18}, // R5 zeros ignored
        {4'd3, 1'b1, 8'hE7, 3'b100, 3'b000, 1'b0, 1'b0, 8'hFB}, // R3 zero flag from ALU
        {4'd4, 1'b0, 8'h00, 3'b011, 3'b000, 1'b0, 1'b0, 8'hF8}, // R4
        {4'd4, 1'b0, 8'h00, 3'b111, 3'b101, 1'b0, 1'b0, 8'hFD}, // R4
        {4'd9, 1'b1, 8'h00, 3'b100, 3'b100, 1'b0, 1'b0, 8'h1C}, // R9 clear
        {4'd3, 1'b1, 8'h47, 3'b011, 3'b000, 1'b0, 1'b0, 8'h5C}, // R3 low flags from ALU
        {4'd6, 1'b0, 8'h00, 3'b000, 3'b000, 1'b1, 1'b0, 8'h54}, // R6 sleep
        {4'd5, 1'b1, 8'h08, 3'b000, 3'b000, 1'b0, 1'b0, 8'h10}, // R5 one ignored
        {4'd6, 1'b0, 8'h00, 3'b000, 3'b000, 1'b0, 1'b1, 8'h00}, // R6 watchdog
        {4'd2, 1'b1, 8'hFF, 3'b000, 3'b000, 1'b0, 1'b0, 8'hE7}, // R2 and R5
        {4'd8, 1'b0, 8'h00, 3'b000, 3'b000, 1'b0, 1'b0, 8'hE7}  // R8 hold
    };

    task automatic check(input string req, input logic [7:0] exp);
        n_vec++;
        if (status_q !== exp) begin
            n_bad++;
            $display("FAIL %s: status actual=%02h expected=%02h", req, status_q, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; wr_data = '0; flag_upd_en = '0; flag_upd_val = '0;
        sleep_evt = 1'b0; wdt_evt = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1", 8'h18);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            wr_en        = VECS[k][24];
            wr_data      = VECS[k][23:16];
            flag_upd_en  = VECS[k][15:13];
            flag_upd_val = VECS[k][12:10];
            sleep_evt    = VECS[k][9];
            wdt_evt      = VECS[k][8];
            @(posedge clk);
            #1;
            check($sformatf("R%0d vec%0d", VECS[k][28:25], k), VECS[k][7:0]);
        end

        // R1: reset restores both cause flags after they were cleared
        do_reset();

        // R7: same-cycle read shows old contents, new value after the edge
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'hA0;
        #1;
        check("R7 same cycle", 8'h18);
        @(posedge clk);
        #1;
        check("R7 next cycle", 8'hB8);

        // R6: watchdog event together with a write that sets the bit
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h1F; wdt_evt = 1'b1;
        @(posedge clk);
        #1;
        check("R6 event during write", 8'h0F);

        // R6 and R4: sleep event with all flags cleared by the ALU
        @(negedge clk);
        idle_inputs();
        sleep_evt = 1'b1; flag_upd_en = 3'b111; flag_upd_val = 3'b000;
        @(posedge clk);
        #1;
        check("R6 sleep with ALU update", 8'h00);

        // R8: ALU updates leave the bank bits alone
        @(negedge clk);
        idle_inputs();
        wr_en = 1'b1; wr_data = 8'h60;
        @(negedge clk);
        idle_inputs();
        flag_upd_en = 3'b111; flag_upd_val = 3'b111;
        @(posedge clk);
        #1;
        check("R8 bank held under ALU", 8'h67);

        @(negedge clk);
        idle_inputs();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule